// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces one active-low system reset from three causes. The first is power-up. The second is a supply-low indication from an external comparator. The third is a watchdog that expires when the shared select/kick line stops showing falling edges. All three causes end in the same way: reset is held for a fixed number of clock cycles and then released.

The supply flag is the block's only asynchronous control. While it is low, every register in the block is cleared and the reset output is low. Power-up is therefore just the case where the flag starts low. Once the flag is high, a hold counter runs for `HOLD_CYC` clock cycles before reset releases. The default of 12,500,000 cycles gives 250 ms at 50 MHz.

After release, the watchdog counts clock cycles. It restarts its count on every high-to-low transition of the select line, after that line has been synchronized. If the count reaches the selected timeout, the watchdog pulls reset low again, and the same hold interval applies. Every length is a parameter, so a bench can use short values.

Top module: `rstsup_top`

## Requirements
- R1: While `supply_ok` is low, `sys_rst_n` is low immediately (asynchronously) and all internal state is cleared.
- R2: After `supply_ok` goes high, `sys_rst_n` goes high at exactly the `HOLD_CYC`-th rising clock edge.
- R3: A low pulse on `supply_ok` during a hold interval, or after release, discards all progress: the next release comes `HOLD_CYC` edges after `supply_ok` goes high again.
- R4: With the watchdog armed, `wd_sel` code 0 selects `TO0_CYC`, code 1 selects `TO1_CYC` and code 2 selects `TO2_CYC`. If no kick occurs, `sys_rst_n` falls at the timeout-th edge after release or after the last kick. A watchdog expiry is the only way `sys_rst_n` can fall while `supply_ok` is high.
- R5: A kick is a high-to-low transition of `csel_kick` after a two-flop synchronizer. A fall made between edges a-1 and a is acted on at edge a+2. A kick on the same edge at which the count would expire wins: reset stays high and the count restarts. A rising transition does not restart the count.
- R6: The watchdog expires whether `csel_kick` is held steadily high or steadily low.
- R7: With `wd_en` low, or with `wd_sel` = 3, the watchdog never asserts reset and its count is held at zero. Arming it again starts a full, fresh timeout.
- R8: A watchdog reset holds `sys_rst_n` low for exactly `HOLD_CYC` edges. After it releases, the watchdog starts a fresh count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that times the hold and the watchdog |
| supply_ok | input | 1 | Supply-valid flag from the external comparator; low means undervoltage (asynchronous) |
| csel_kick | input | 1 | Shared select line; each falling edge restarts the watchdog |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Timeout select: 0, 1, 2 pick the presets; 3 turns the watchdog off |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
Two functions can land on the same clock edge. The first case is a synchronized kick on the very edge at which the watchdog count would expire. The bench provokes it by dropping the select line exactly two edges ahead of the expiry edge. It then judges the result by checking that reset stays high past that edge, and that the next expiry comes one full timeout after the kick. The second case is a supply drop colliding with a running hold or watchdog count. Here the per-clock reference model and the measured release distance show that the asynchronous clear overrides whatever the counters were doing.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef enum logic [1:0] {
    WSEL_SHORT = 2'd0,
    WSEL_MID   = 2'd1,
    WSEL_LONG  = 2'd2,
    WSEL_OFF   = 2'd3
  } wsel_e;

  function automatic int rs_cnt_width(input int a, input int b,
                                      input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic fall
);
  // chain: STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-1:0], din};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/rstsup_hold.sv
module rstsup_hold #(
  parameter int HOLD_CYC = 12_500_000,
  parameter int CW       = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig,
  output logic rel
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rel <= 1'b0;
      cnt <= '0;
    end else if (!rel) begin
      if (cnt == LAST) begin
        rel <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (trig) begin
      rel <= 1'b0;
      cnt <= '0;
    end
  end
endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog
  import rstsup_pkg::*;
#(
  parameter int TO0_CYC = 10_000_000,
  parameter int TO1_CYC = 30_000_000,
  parameter int TO2_CYC = 70_000_000,
  parameter int CW      = 27
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       run,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       kick,
  output logic       bark
);
  localparam logic [CW-1:0] LIM0 = CW'(TO0_CYC - 1);
  localparam logic [CW-1:0] LIM1 = CW'(TO1_CYC - 1);
  localparam logic [CW-1:0] LIM2 = CW'(TO2_CYC - 1);

  logic [CW-1:0] wcnt;
  logic [CW-1:0] lim;
  logic          act;

  always_comb begin
    unique case (wsel_e'(sel))
      WSEL_SHORT: lim = LIM0;
      WSEL_MID:   lim = LIM1;
      WSEL_LONG:  lim = LIM2;
      default:    lim = LIM2;
    endcase
  end

  assign act  = run & en & (wsel_e'(sel) != WSEL_OFF);
  assign bark = act & ~kick & (wcnt >= lim);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                     wcnt <= '0;
    else if (!act || kick || bark)   wcnt <= '0;
    else                             wcnt <= wcnt + 1'b1;
  end
endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter int HOLD_CYC = 12_500_000,
  parameter int TO0_CYC  = 10_000_000,
  parameter int TO1_CYC  = 30_000_000,
  parameter int TO2_CYC  = 70_000_000,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       csel_kick,
  input  logic       wd_en,
  input  logic [1:0] wd_sel,
  output logic       sys_rst_n
);
  localparam int CW = rs_cnt_width(HOLD_CYC, TO0_CYC, TO1_CYC, TO2_CYC);

  logic kick;
  logic bark;
  logic rel;

  rstsup_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .arst_n (supply_ok),
    .din    (csel_kick),
    .fall   (kick)
  );

  rstsup_wdog #(
    .TO0_CYC (TO0_CYC),
    .TO1_CYC (TO1_CYC),
    .TO2_CYC (TO2_CYC),
    .CW      (CW)
  ) u_wdog (
    .clk    (clk),
    .arst_n (supply_ok),
    .run    (rel),
    .en     (wd_en),
    .sel    (wd_sel),
    .kick   (kick),
    .bark   (bark)
  );

  rstsup_hold #(.HOLD_CYC(HOLD_CYC), .CW(CW)) u_hold (
    .clk    (clk),
    .arst_n (supply_ok),
    .trig   (bark),
    .rel    (rel)
  );

  assign sys_rst_n = rel;
endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk #(
  parameter int HOLD_CYC = 12_500_000,
  parameter int TO0_CYC  = 10_000_000,
  parameter int TO1_CYC  = 30_000_000,
  parameter int TO2_CYC  = 70_000_000
) (
  input logic       clk,
  input logic       supply_ok,
  input logic       sys_rst_n,
  input logic       kick,
  input logic       bark,
  input logic       wd_en,
  input logic [1:0] wd_sel
);
  int  lowcnt;
  int  idle;
  int  lim;
  logic armed;

  assign armed = sys_rst_n && wd_en && (wd_sel != 2'd3);
  assign lim   = (wd_sel == 2'd0) ? TO0_CYC :
                 (wd_sel == 2'd1) ? TO1_CYC : TO2_CYC;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)     lowcnt <= 0;
    else if (sys_rst_n) lowcnt <= 0;
    else                lowcnt <= lowcnt + 1;
  end

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)                idle <= 0;
    else if (!armed || kick)       idle <= 0;
    else                           idle <= idle + 1;
  end

  // R1
  sup_low_rst_chk: assert property (@(posedge clk)
    !supply_ok |-> !sys_rst_n);

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(sys_rst_n) |-> lowcnt == HOLD_CYC);

  // R4
  wd_cause_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(sys_rst_n) |-> $past(bark));

  // R4
  wd_span_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    bark |-> idle >= lim - 1);

  // R7
  wd_off_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    (!wd_en || wd_sel == 2'd3) |-> !bark);
endmodule

bind rstsup_top rstsup_chk #(
  .HOLD_CYC (HOLD_CYC),
  .TO0_CYC  (TO0_CYC),
  .TO1_CYC  (TO1_CYC),
  .TO2_CYC  (TO2_CYC)
) u_chk (
  .clk       (clk),
  .supply_ok (supply_ok),
  .sys_rst_n (sys_rst_n),
  .kick      (kick),
  .bark      (bark),
  .wd_en     (wd_en),
  .wd_sel    (wd_sel)
);

// File: tb/sim_rstsup_top.sv
`timescale 1ns/1ps
module sim_rstsup_top;
  localparam int HOLD = 20;
  localparam int T0   = 30;
  localparam int T1   = 50;
  localparam int T2   = 80;

  logic       clk = 1'b0;
  logic       supply_ok;
  logic       csel_kick;
  logic       wd_en;
  logic [1:0] wd_sel;
  logic       sys_rst_n;

  int total = 0;
  int bad   = 0;
  bit started = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  rstsup_top #(
    .HOLD_CYC (HOLD),
    .TO0_CYC  (T0),
    .TO1_CYC  (T1),
    .TO2_CYC  (T2)
  ) u0 (
    .clk       (clk),
    .supply_ok (supply_ok),
    .csel_kick (csel_kick),
    .wd_en     (wd_en),
    .wd_sel    (wd_sel),
    .sys_rst_n (sys_rst_n)
  );

  // behavioural reference: edges since cause, idle edges since kick
  bit m_rel;
  int m_hc, m_idle;
  bit q1, q2, q3;

  always @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      m_rel = 0; m_hc = 0; m_idle = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      bit k;
      int lim;
      k  = q3 && !q2;
      q3 = q2; q2 = q1; q1 = csel_kick;
      lim = (wd_sel == 2'd0) ? T0 : (wd_sel == 2'd1) ? T1 : T2;
      if (!m_rel) begin
        m_hc++;
        m_idle = 0;
        if (m_hc == HOLD) begin m_rel = 1; m_hc = 0; end
      end else if (!wd_en || wd_sel == 2'd3 || k) begin
        m_idle = 0;
      end else if (m_idle + 1 >= lim) begin
        m_rel = 0; m_hc = 0; m_idle = 0;
      end else begin
        m_idle++;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if (sys_rst_n !== m_rel) begin
        bad++;
        $display("FAIL R2/R4/R8 per-cycle model: actual=%b expected=%b at %0t",
                 sys_rst_n, m_rel, $time);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input logic val, input int lim, output int n);
    n = 0;
    while (sys_rst_n !== val && n < lim) begin tick(); n++; end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL all: watchdog expired actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int n;
    supply_ok = 1'b1; csel_kick = 1'b1; wd_en = 1'b1; wd_sel = 2'd0;
    #1 supply_ok = 1'b0;
    tick(5);
    chk(sys_rst_n === 1'b0, "R1 power-up reset", sys_rst_n, 0);
    started = 1;

    supply_ok = 1'b1;
    meas(1'b1, 200, n);
    chk(n == HOLD, "R2 first hold length", n, HOLD);

    meas(1'b0, 300, n);
    chk(n == T0, "R6 timeout with select held high", n, T0);
    meas(1'b1, 200, n);
    chk(n == HOLD, "R8 hold after watchdog", n, HOLD);

    csel_kick = 1'b0;
    meas(1'b0, 300, n);
    chk(n == T0 + 3, "R5 kick latency through synchronizer", n, T0 + 3);
    meas(1'b1, 200, n);
    meas(1'b0, 300, n);
    chk(n == T0, "R6 timeout with select held low", n, T0);
    meas(1'b1, 200, n);

    tick(10);
    csel_kick = 1'b1;
    meas(1'b0, 300, n);
    chk(n + 10 == T0, "R5 rising edge does not restart", n + 10, T0);
    meas(1'b1, 200, n);

    for (int i = 0; i < 12; i++) begin
      tick(8); csel_kick = 1'b0;
      tick(8); csel_kick = 1'b1;
    end
    chk(sys_rst_n === 1'b1, "R5 periodic kicks keep reset high", sys_rst_n, 1);
    meas(1'b0, 300, n);
    meas(1'b1, 200, n);

    wd_sel = 2'd1;
    meas(1'b0, 300, n);
    chk(n == T1, "R4 code 1 timeout", n, T1);
    meas(1'b1, 200, n);
    wd_sel = 2'd2;
    meas(1'b0, 300, n);
    chk(n == T2, "R4 code 2 timeout", n, T2);
    meas(1'b1, 200, n);

    wd_sel = 2'd3;
    tick(200);
    chk(sys_rst_n === 1'b1, "R7 code 3 disables", sys_rst_n, 1);
    wd_sel = 2'd0; wd_en = 1'b0;
    tick(200);
    chk(sys_rst_n === 1'b1, "R7 enable low disables", sys_rst_n, 1);
    wd_en = 1'b1;
    meas(1'b0, 300, n);
    chk(n == T0, "R7 re-armed gives full timeout", n, T0);
    meas(1'b1, 200, n);

    tick(T0 - 3);
    csel_kick = 1'b0;
    tick(3);
    chk(sys_rst_n === 1'b1, "R5 kick on expiry edge wins", sys_rst_n, 1);
    meas(1'b0, 300, n);
    chk(n == T0, "R5 count restarted by same-edge kick", n, T0);
    meas(1'b1, 200, n);

    tick(7);
    supply_ok = 1'b0;
    #1;
    chk(sys_rst_n === 1'b0, "R1 asynchronous supply drop", sys_rst_n, 0);
    tick(3);
    supply_ok = 1'b1;
    tick(HOLD / 2);
    supply_ok = 1'b0;
    tick(1);
    supply_ok = 1'b1;
    meas(1'b1, 200, n);
    chk(n == HOLD, "R3 fresh hold after drop mid-hold", n, HOLD);

    tick(5);
    finish_up();
  end
endmodule